// File: doc/BRIEF.md
# Pruned List Trellis Decoder

This block decodes a rate-1/2 systematic convolutional code with two memory bits, so the trellis has four states. Each received symbol is a pair of 4-bit signed soft values, one systematic and one parity. A positive value means the transmitted bit was 1. The decoder does not keep one survivor per trellis state. It keeps a ranked list of candidate paths. At every step it extends each listed path with both possible input bits and scores each extension by correlation with the received pair. Each scored extension goes into a sorted list whose length is capped by a runtime path limit. The decoder then drops every path that trails the best path by more than a programmable threshold.

Each path carries its own 16-bit decision history. Once 16 symbols have been consumed, every further step produces one hard decision, taken from the oldest bit of the best path's history. The path limit and the threshold are meant to be retuned at block boundaries: a large list when the channel is poor, a short list when it is clean. Because the step length grows with the list size, a shorter list also means fewer cycles per symbol.

Top module: `sova_list_dec`

## Requirements
- R1: After reset the list holds one path (state 0, metric 0, empty history), `sym_ready_o` is high and `bit_valid_o` is low.
- R2: A symbol is taken in the cycle where `sym_valid_i` and `sym_ready_o` are both high. If P paths are listed when the symbol is taken, `sym_ready_o` then stays low for exactly 2P+1 cycles.
- R3: The encoder state is s[1:0], with s[1] holding the newest input. For input u, the parity is u^s[1]^s[0] and the next state is {u,s[1]}. The branch metric is (u ? r : -r) + (p ? q : -q), where r and q are the systematic and parity soft values and p is the parity bit of that branch.
- R4: An extended path is kept only if its metric minus the best metric is at least T. T is `thresh_i`, read as a 12-bit two's complement value.
- R5: If no path other than the best meets the threshold, including the case T > 0, the best path alone is kept, so the list is never empty.
- R6: The list never holds more than the path limit. When more extensions exist than the limit allows, the ones with the highest metrics are kept.
- R7: A `max_paths_i` value of 0 acts as 1, and a value above 8 acts as 8.
- R8: The path limit and the threshold are sampled when a symbol is taken. Changing them while a step is in progress has no effect on that step.
- R9: Extensions are produced in list order, with u=0 before u=1 for each path. On equal metrics the earlier extension ranks higher.
- R10: After every step the best metric is renormalised to 0, and the other metrics are saturated at -2048. Decoding stays correct over runs of any length.
- R11: The step that consumes the 16th symbol, and every step after it, gives one `bit_valid_o` pulse in the first cycle `sym_ready_o` is high again. That pulse carries the decision for the symbol taken 15 symbols earlier.
- R12: Noise-free symbol streams, and streams with isolated erased soft values (value 0), are decoded to the transmitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol pair offered |
| sym_ready_o | output | 1 | Decoder idle and able to take a symbol |
| sym_sys_i | input | 4 | Systematic soft value, signed |
| sym_par_i | input | 4 | Parity soft value, signed |
| max_paths_i | input | 4 | Path limit, 1 to 8 |
| thresh_i | input | 12 | Pruning threshold relative to the best metric, signed |
| bit_valid_o | output | 1 | Decision strobe, one cycle |
| bit_o | output | 1 | Decoded bit |

## Verification
A new path limit or threshold can arrive while a step is still working through its extensions. That update then meets the cap the step applied when its symbol was taken. The bench provokes this by growing the list to eight paths, taking a symbol, and then driving a limit of one and a positive threshold during the busy window. It judges the result by the busy time of the current step and of the next two steps: 17, 17 and then 3 cycles. This shows the old settings finished the step in flight and the new limit took hold only at the next symbol.

// File: rtl/sova_pkg.sv
package sova_pkg;
  localparam int unsigned MEM_BITS  = 2;
  localparam int unsigned SOFT_W    = 4;
  localparam int unsigned PM_W      = 12;
  localparam int unsigned MAX_PATHS = 8;
  localparam int unsigned TB_DEPTH  = 16;
  localparam int unsigned BM_W      = SOFT_W + 2;
  localparam int unsigned IDX_W     = $clog2(MAX_PATHS);
  localparam int unsigned CNT_W     = $clog2(MAX_PATHS + 1);
  localparam int unsigned CAND_W    = IDX_W + 1;
  localparam int unsigned STEP_W    = $clog2(TB_DEPTH);

  typedef logic signed [PM_W-1:0] pm_t;

  typedef struct packed {
    logic [MEM_BITS-1:0] st;
    pm_t                 pm;
    logic [TB_DEPTH-1:0] hist;
  } path_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EXP, ST_FIN} fsm_e;

  function automatic pm_t sat_pm(input logic signed [PM_W:0] v);
    if (v > $signed({2'b00, {(PM_W-1){1'b1}}}))      return {1'b0, {(PM_W-1){1'b1}}};
    else if (v < $signed({2'b11, {(PM_W-1){1'b0}}})) return {1'b1, {(PM_W-1){1'b0}}};
    else                                             return v[PM_W-1:0];
  endfunction
endpackage

// File: rtl/sova_bmu.sv
module sova_bmu
  import sova_pkg::*;
(
  input  logic [MEM_BITS-1:0]      st_i,
  input  logic                     u_i,
  input  logic signed [SOFT_W-1:0] sys_i,
  input  logic signed [SOFT_W-1:0] par_i,
  output logic [MEM_BITS-1:0]      nxt_o,
  output logic signed [BM_W-1:0]   bm_o
);
  logic par;
  logic signed [BM_W-1:0] s_ext, p_ext;

  always_comb begin
    par   = u_i ^ (^st_i);
    nxt_o = {u_i, st_i[MEM_BITS-1:1]};
    s_ext = {{(BM_W-SOFT_W){sys_i[SOFT_W-1]}}, sys_i};
    p_ext = {{(BM_W-SOFT_W){par_i[SOFT_W-1]}}, par_i};
    bm_o  = (u_i ? s_ext : -s_ext) + (par ? p_ext : -p_ext);
  end
endmodule

// File: rtl/sova_ins.sv
// Sorted insert of one candidate; equal metrics keep earlier entries ahead.
module sova_ins
  import sova_pkg::*;
(
  input  path_t            list_i [MAX_PATHS],
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] lim_i,
  input  path_t            cand_i,
  output path_t            list_o [MAX_PATHS],
  output logic [CNT_W-1:0] fill_o
);
  logic [CNT_W-1:0] pos;
  logic             ins;

  always_comb begin
    pos = '0;
    for (int k = 0; k < MAX_PATHS; k++)
      if (CNT_W'(k) < fill_i && $signed(list_i[k].pm) >= $signed(cand_i.pm))
        pos = pos + CNT_W'(1);
    ins    = pos < lim_i;
    fill_o = (ins && fill_i < lim_i) ? fill_i + CNT_W'(1) : fill_i;
  end

  for (genvar k = 0; k < MAX_PATHS; k++) begin : g_slot
    if (k == 0) begin : g_head
      always_comb
        list_o[k] = (ins && pos == '0) ? cand_i : list_i[k];
    end else begin : g_tail
      always_comb begin
        if (!ins || CNT_W'(k) < pos) list_o[k] = list_i[k];
        else if (CNT_W'(k) == pos)   list_o[k] = cand_i;
        else                         list_o[k] = list_i[k-1];
      end
    end
  end
endmodule

// File: rtl/sova_prune.sv
// Threshold pruning on a sorted list plus renormalisation to the best metric.
module sova_prune
  import sova_pkg::*;
(
  input  path_t            list_i [MAX_PATHS],
  input  logic [CNT_W-1:0] fill_i,
  input  pm_t              thr_i,
  output path_t            list_o [MAX_PATHS],
  output logic [CNT_W-1:0] cnt_o
);
  pm_t                  best;
  logic [MAX_PATHS-1:0] keep;

  assign best = list_i[0].pm;

  for (genvar k = 0; k < MAX_PATHS; k++) begin : g_ent
    logic signed [PM_W:0] diff;
    always_comb begin
      diff      = $signed({list_i[k].pm[PM_W-1], list_i[k].pm}) - $signed({best[PM_W-1], best});
      keep[k]   = (k == 0) ||
                  (CNT_W'(k) < fill_i && diff >= $signed({thr_i[PM_W-1], thr_i}));
      list_o[k] = '{st: list_i[k].st, pm: sat_pm(diff), hist: list_i[k].hist};
    end
  end

  // sorted list: kept entries form a prefix
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < MAX_PATHS; k++)
      if (keep[k]) cnt_o = cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/sova_list_dec.sv
module sova_list_dec
  import sova_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  output logic              sym_ready_o,
  input  logic [SOFT_W-1:0] sym_sys_i,
  input  logic [SOFT_W-1:0] sym_par_i,
  input  logic [CNT_W-1:0]  max_paths_i,
  input  logic [PM_W-1:0]   thresh_i,
  output logic              bit_valid_o,
  output logic              bit_o
);
  fsm_e                    state_q;
  path_t                   list_q [MAX_PATHS];
  path_t                   acc_q  [MAX_PATHS];
  logic [CNT_W-1:0]        cnt_q, fill_q, lim_q, lim_sel;
  logic [CAND_W-1:0]       idx_q;
  logic signed [SOFT_W-1:0] sys_q, par_q;
  pm_t                     thr_q;
  logic [STEP_W-1:0]       steps_q;
  logic                    bit_valid_q, bit_q;

  path_t                   cur, cand;
  logic [MEM_BITS-1:0]     nxt;
  logic signed [BM_W-1:0]  bm;
  logic                    last_cand;
  path_t                   ins_list [MAX_PATHS];
  logic [CNT_W-1:0]        ins_fill;
  path_t                   prn_list [MAX_PATHS];
  logic [CNT_W-1:0]        prn_cnt;
  pm_t                     pm_view [MAX_PATHS];

  assign sym_ready_o = (state_q == ST_IDLE);
  assign bit_valid_o = bit_valid_q;
  assign bit_o       = bit_q;

  assign cur = list_q[idx_q[CAND_W-1:1]];

  sova_bmu u_bmu (
    .st_i (cur.st),
    .u_i  (idx_q[0]),
    .sys_i(sys_q),
    .par_i(par_q),
    .nxt_o(nxt),
    .bm_o (bm)
  );

  always_comb begin
    cand.st   = nxt;
    cand.pm   = sat_pm($signed({cur.pm[PM_W-1], cur.pm}) +
                       $signed({{(PM_W+1-BM_W){bm[BM_W-1]}}, bm}));
    cand.hist = TB_DEPTH'({cur.hist, idx_q[0]});
    last_cand = ((CNT_W+1)'(idx_q) + (CNT_W+1)'(1)) == {cnt_q, 1'b0};
    if (max_paths_i == '0)                    lim_sel = CNT_W'(1);
    else if (max_paths_i > CNT_W'(MAX_PATHS)) lim_sel = CNT_W'(MAX_PATHS);
    else                                      lim_sel = max_paths_i;
    for (int k = 0; k < MAX_PATHS; k++) pm_view[k] = list_q[k].pm;
  end

  sova_ins u_ins (
    .list_i(acc_q),
    .fill_i(fill_q),
    .lim_i (lim_q),
    .cand_i(cand),
    .list_o(ins_list),
    .fill_o(ins_fill)
  );

  sova_prune u_prune (
    .list_i(acc_q),
    .fill_i(fill_q),
    .thr_i (thr_q),
    .list_o(prn_list),
    .cnt_o (prn_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      for (int k = 0; k < MAX_PATHS; k++) begin
        list_q[k] <= '0;
        acc_q[k]  <= '0;
      end
      cnt_q       <= CNT_W'(1);
      fill_q      <= '0;
      lim_q       <= CNT_W'(MAX_PATHS);
      idx_q       <= '0;
      sys_q       <= '0;
      par_q       <= '0;
      thr_q       <= '0;
      steps_q     <= '0;
      bit_valid_q <= 1'b0;
      bit_q       <= 1'b0;
    end else begin
      bit_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (sym_valid_i) begin
          sys_q   <= sym_sys_i;
          par_q   <= sym_par_i;
          lim_q   <= lim_sel;
          thr_q   <= thresh_i;
          fill_q  <= '0;
          idx_q   <= '0;
          state_q <= ST_EXP;
        end
        ST_EXP: begin
          acc_q  <= ins_list;
          fill_q <= ins_fill;
          idx_q  <= idx_q + CAND_W'(1);
          if (last_cand) state_q <= ST_FIN;
        end
        ST_FIN: begin
          list_q  <= prn_list;
          cnt_q   <= prn_cnt;
          state_q <= ST_IDLE;
          if (steps_q == STEP_W'(TB_DEPTH-1)) begin
            bit_valid_q <= 1'b1;
            bit_q       <= acc_q[0].hist[TB_DEPTH-1];
          end else begin
            steps_q <= steps_q + STEP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sova_list_dec_chk.sv
module sova_list_dec_chk
  import sova_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input fsm_e             state_i,
  input logic             sym_valid_i,
  input logic             sym_ready_i,
  input logic             bit_valid_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] lim_i,
  input pm_t              thr_i,
  input pm_t              pm_i [MAX_PATHS]
);
  logic [IDX_W-1:0] last_idx;
  assign last_idx = IDX_W'(cnt_i - CNT_W'(1));

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_i) |=> !sym_ready_i);

  a_r6_list_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIN) |=> (cnt_i >= CNT_W'(1) && cnt_i <= lim_i));

  a_r10_best_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIN) |=> (pm_i[0] == '0));

  a_r4_kept_meet_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIN) |=> (cnt_i == CNT_W'(1) || $signed(pm_i[last_idx]) >= $signed(thr_i)));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> !bit_valid_i);

  a_r8_limit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(lim_i));
endmodule

bind sova_list_dec sova_list_dec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_q),
  .sym_valid_i(sym_valid_i),
  .sym_ready_i(sym_ready_o),
  .bit_valid_i(bit_valid_o),
  .cnt_i      (cnt_q),
  .lim_i      (lim_q),
  .thr_i      (thr_q),
  .pm_i       (pm_view)
);

// File: tb/sova_list_dec_tb_top.sv
module sova_list_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [3:0]  sys_v = '0, par_v = '0, max_v = 4'd8;
  logic [11:0] thr_v = '0;
  logic        bv, bo;

  int checks = 0, errors = 0;
  bit out_bits [0:511];
  int out_n = 0;
  bit data_bits [0:511];
  logic [1:0]  enc_st = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sova_list_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(valid), .sym_ready_o(ready),
    .sym_sys_i(sys_v), .sym_par_i(par_v), .max_paths_i(max_v), .thresh_i(thr_v),
    .bit_valid_o(bv), .bit_o(bo)
  );

  always @(negedge clk) if (rst_n && bv) begin
    if (out_n < 512) out_bits[out_n] = bo;
    out_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int m, input int t);
    valid = 1'b0; max_v = m[3:0]; thr_v = t[11:0];
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    out_n = 0; enc_st = '0;
  endtask

  task automatic send_mid(input int r, input int q, input bit mid, input int m2, input int t2,
                          output int low);
    @(negedge clk);
    while (!ready) @(negedge clk);
    sys_v = r[3:0]; par_v = q[3:0]; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (mid) begin max_v = m2[3:0]; thr_v = t2[11:0]; end
    low = 0;
    while (!ready) begin low++; @(negedge clk); end
    #1;
  endtask

  task automatic send(input int r, input int q, output int low);
    send_mid(r, q, 1'b0, 0, 0, low);
  endtask

  task automatic send_coded(input bit u, input bit er_s, input bit er_p, output int low);
    bit p;
    p = u ^ enc_st[1] ^ enc_st[0];
    enc_st = {u, enc_st[1]};
    send(er_s ? 0 : (u ? 7 : -7), er_p ? 0 : (p ? 7 : -7), low);
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic t_reset();
    int low;
    do_reset(8, -2048);
    chk(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(bv === 1'b0, "R1 no strobe after reset", int'(bv), 0);
    send_coded(1'b0, 1'b0, 1'b0, low);
    chk(low == 3, "R1 single path at start (R2 busy 2P+1)", low, 3);
  endtask

  task automatic t_growth();
    int exp_l [6] = '{3, 5, 9, 17, 17, 17};
    int low;
    do_reset(8, -2048);
    for (int i = 0; i < 6; i++) begin
      send_coded(1'b0, 1'b0, 1'b0, low);
      chk(low == exp_l[i], "R6 list growth capped at 8 (R2)", low, exp_l[i]);
    end
  endtask

  task automatic t_thresh();
    int low;
    do_reset(8, -27);
    send(-7, -7, low); send(-7, -7, low);
    chk(low == 3, "R4 gap 28 below T=-27 dropped", low, 3);
    do_reset(8, -28);
    send(-7, -7, low); send(-7, -7, low);
    chk(low == 5, "R4 gap 28 at T=-28 kept (R3)", low, 5);
    do_reset(8, 5);
    for (int i = 0; i < 3; i++) send(-7, -7, low);
    chk(low == 3, "R5 positive T keeps best only", low, 3);
    do_reset(8, 0);
    send(7, -7, low); send(7, -7, low);
    chk(low == 5, "R3 parity tie u0/u1 from state 0", low, 5);
    do_reset(8, 0);
    send(7, 7, low); send(7, 7, low);
    chk(low == 3, "R3 u=1 branch alone best", low, 3);
  endtask

  task automatic t_mlimit();
    int e3 [4] = '{3, 5, 7, 7};
    int e15 [4] = '{3, 5, 9, 17};
    int low;
    do_reset(3, -2048);
    for (int i = 0; i < 4; i++) begin
      send(-7, -7, low);
      chk(low == e3[i], "R6 limit 3", low, e3[i]);
    end
    do_reset(0, -2048);
    for (int i = 0; i < 3; i++) send(-7, -7, low);
    chk(low == 3, "R7 limit 0 acts as 1", low, 3);
    do_reset(15, -2048);
    for (int i = 0; i < 4; i++) begin
      send(-7, -7, low);
      chk(low == e15[i], "R7 limit 15 acts as 8", low, e15[i]);
    end
  endtask

  task automatic t_mlatch();
    int low;
    do_reset(8, -2048);
    for (int i = 0; i < 4; i++) send(-7, -7, low);
    send_mid(-7, -7, 1'b1, 1, 100, low);
    chk(low == 17, "R8 change mid-step no effect on current", low, 17);
    send(-7, -7, low);
    chk(low == 17, "R8 in-flight step kept 8 paths", low, 17);
    send(-7, -7, low);
    chk(low == 3, "R8 new limit applies next step", low, 3);
  endtask

  task automatic t_decode();
    int low, miss;
    do_reset(8, -2048);
    for (int i = 0; i < 40; i++) begin
      data_bits[i] = next_bit();
      send_coded(data_bits[i], i == 10, i == 22, low);
      if (i == 14) chk(out_n == 0, "R11 no bit before 16th symbol", out_n, 0);
      if (i == 15) chk(out_n == 1, "R11 first bit on 16th symbol", out_n, 1);
    end
    chk(out_n == 25, "R11 one bit per step", out_n, 25);
    miss = 0;
    for (int i = 0; i < 25; i++) if (out_bits[i] != data_bits[i]) miss++;
    chk(miss == 0, "R12 decode with erasures", miss, 0);
  endtask

  task automatic t_tie();
    int low, ones;
    do_reset(8, -2048);
    for (int i = 0; i < 20; i++) send(0, 0, low);
    ones = 0;
    for (int i = 0; i < out_n; i++) if (out_bits[i]) ones++;
    chk(out_n == 5 && ones == 0, "R9 ties favour earlier extension", ones, 0);
  endtask

  task automatic t_renorm();
    int low, miss;
    do_reset(4, -2048);
    for (int i = 0; i < 300; i++) begin
      data_bits[i] = next_bit();
      send_coded(data_bits[i], 1'b0, 1'b0, low);
    end
    miss = 0;
    for (int i = 0; i < 285; i++) if (out_bits[i] != data_bits[i]) miss++;
    chk(out_n == 285, "R11 bit count long run", out_n, 285);
    chk(miss == 0, "R10 long run decodes without overflow", miss, 0);
  endtask

  initial begin
    t_reset();
    t_growth();
    t_thresh();
    t_mlimit();
    t_mlatch();
    t_decode();
    t_tie();
    t_renorm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule